// File: doc/BRIEF.md
# Direct-Mapped Cache with Parity and Snoop Invalidation

This block is a small direct-mapped cache placed between a 16-bit processor port and a 32-bit main-memory port. A processor read looks up one line chosen by the low address bits and compares the stored tag. A hit answers in the same cycle. A miss fetches a whole two-word line from memory, which brings in the neighbouring word as well, and the read is answered once that line is in place. Processor writes go straight through to memory. A line that is already present is updated in place, and a write to an address that is not present allocates nothing.

A snoop input reports memory writes made by other bus masters. Any resident line that such a write hits is invalidated in the same cycle, and the processor side is never stalled by it. Every line holds even-parity bits for each of its data bytes and one for its tag. A parity mismatch is treated as a miss, which forces a refill, and it also raises a sticky error flag.

Top module: `dm_cache`

## Requirements
- R1: Reset clears every valid bit, drives `cpu_ready`, `mem_req` and `parity_err` low, and makes the first read of any address a miss.
- R2: A read that hits raises `cpu_ready` in the same cycle as the request. `cpu_rdata` then holds the addressed word, and address bit 0 picks the odd (1) or even (0) word of the line.
- R3: A read miss raises `mem_req` with `mem_we` low and `mem_addr` equal to the request address with bit 0 cleared, and holds both until `mem_ready`. `mem_rdata[15:0]` is the even word and `mem_rdata[31:16]` is the odd word. `cpu_ready` stays low until the line is written, and the read hits in the cycle after that (three cycles in total with a memory that answers in its second request cycle). The other word of the line hits afterwards.
- R4: Address bits [4:1] select the line and bits [15:5] form the tag. Two addresses with the same index and different tags evict each other.
- R5: A write raises `mem_req` and `mem_we` with the full word address on `mem_addr` and the data on `mem_wdata`. `cpu_ready` is high in the `mem_ready` cycle. A resident line takes the new word, and a write that misses leaves the line it maps to unchanged.
- R6: A snoop whose index and tag match a valid line invalidates it at the end of the snoop cycle, and a snoop whose tag does not match has no effect. A processor hit in the same cycle as a snoop still completes in that cycle.
- R7: If a fill completes in the same cycle as a snoop to the same index, the line ends invalid and the read refills it. A snoop that arrives before the fill completes does not prevent the fill from leaving the line valid.
- R8: Each line keeps an even-parity bit (the XOR of the bits) for every data byte and for its tag. A mismatch on the tag or on a byte of the addressed word makes the read a miss that refills the line, and it sets `parity_err`.
- R9: Once set, `parity_err` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Processor word address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Read data, valid while `cpu_ready` is high on a read |
| cpu_ready | output | 1 | Request completes at this clock edge |
| mem_req | output | 1 | Memory request, held until `mem_ready` |
| mem_we | output | 1 | Memory write (1) or line fetch (0) |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 32 | Fetched line, even word in the low half |
| mem_ready | input | 1 | Memory completes the request at this edge |
| snoop_valid | input | 1 | Another master writes memory this cycle |
| snoop_addr | input | 16 | Word address of that write |
| parity_err | output | 1 | Sticky parity error flag |

## Verification
A read hit is due in the request cycle itself. The bench memory answers in the second cycle of its request, so a miss is due three cycles after the request, a fill undone by a colliding snoop costs six cycles, and a write is acknowledged in its second cycle. The bench drives inputs on the falling edge and samples 1 ns later. It counts the falling edges until `cpu_ready` and compares that count against these exact figures, so a wrong latency is reported and not absorbed by waiting. Snoops come from the bench memory at chosen points of a fill, and their effect is judged by the latency and data of the next read. Sticky flags are sampled one cycle after the edge that sets them.

// File: rtl/dmc_pkg.sv
`timescale 1ns/1ps
package dmc_pkg;
    localparam int ADDR_W  = 16;
    localparam int WORD_W  = 16;
    localparam int INDEX_W = 4;
    localparam int WPL     = 2;
    localparam int OFF_W   = $clog2(WPL);
    localparam int TAG_W   = ADDR_W - INDEX_W - OFF_W;
    localparam int LINES   = 1 << INDEX_W;
    localparam int LINE_W  = WORD_W * WPL;
    localparam int BPW     = WORD_W / 8;
    localparam int NBYTES  = BPW * WPL;
    localparam int PAR_W   = NBYTES + 1;   // top bit covers the tag

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [INDEX_W-1:0] idx_t;
    typedef logic [TAG_W-1:0]   tag_t;
    typedef logic [OFF_W-1:0]   off_t;
    typedef logic [LINE_W-1:0]  line_t;
    typedef logic [PAR_W-1:0]   par_t;

    typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_WRITE} ctl_state_e;

    typedef struct packed {
        tag_t tag;
        idx_t idx;
        off_t off;
    } addr_f_t;

    typedef struct packed {
        logic  valid;
        tag_t  tag;
        line_t data;
        par_t  par;
    } entry_t;

    function automatic addr_f_t split_addr(input addr_t a);
        return addr_f_t'(a);
    endfunction

    function automatic par_t gen_par(input tag_t t, input line_t d);
        par_t p;
        for (int b = 0; b < NBYTES; b++) p[b] = ^d[b*8 +: 8];
        p[PAR_W-1] = ^t;
        return p;
    endfunction
endpackage

// File: rtl/dmc_store.sv
`timescale 1ns/1ps
module dmc_store import dmc_pkg::*; (
    input  logic   clk,
    input  logic   rst,
    input  idx_t   rd_idx,
    output entry_t rd_entry,
    input  idx_t   snp_idx,
    output logic   snp_valid,
    output tag_t   snp_tag,
    input  logic   fill_en,
    input  idx_t   fill_idx,
    input  tag_t   fill_tag,
    input  line_t  fill_data,
    input  logic   wr_en,
    input  idx_t   wr_idx,
    input  off_t   wr_off,
    input  word_t  wr_word,
    input  logic   inv_en,
    input  idx_t   inv_idx
);
    logic valid_q [LINES];
    tag_t tag_q   [LINES];
    line_t data_q [LINES];
    logic [LINES-1:0][PAR_W-1:0] par_q;
    line_t upd_line;

    // Valid bits: invalidation beats a fill on the same line.
    for (genvar i = 0; i < LINES; i++) begin : g_valid
        always_ff @(posedge clk) begin
            if (rst)
                valid_q[i] <= 1'b0;
            else if (inv_en && inv_idx == idx_t'(i))
                valid_q[i] <= 1'b0;
            else if (fill_en && fill_idx == idx_t'(i))
                valid_q[i] <= 1'b1;
        end
    end

    always_comb begin
        upd_line = data_q[wr_idx];
        upd_line[int'(wr_off)*WORD_W +: WORD_W] = wr_word;
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx]  <= fill_tag;
            data_q[fill_idx] <= fill_data;
            par_q[fill_idx]  <= gen_par(fill_tag, fill_data);
        end else if (wr_en) begin
            data_q[wr_idx] <= upd_line;
            par_q[wr_idx]  <= gen_par(tag_q[wr_idx], upd_line);
        end
    end

    assign rd_entry = '{valid: valid_q[rd_idx], tag: tag_q[rd_idx],
                        data: data_q[rd_idx], par: par_q[rd_idx]};
    assign snp_valid = valid_q[snp_idx];
    assign snp_tag   = tag_q[snp_idx];
endmodule

// File: rtl/dmc_lookup.sv
`timescale 1ns/1ps
module dmc_lookup import dmc_pkg::*; (
    input  addr_f_t fa,
    input  entry_t  e,
    output logic    hit,
    output logic    perr,
    output word_t   word
);
    logic [BPW-1:0] byte_bad;
    logic tag_bad;

    assign word = e.data[int'(fa.off)*WORD_W +: WORD_W];

    for (genvar b = 0; b < BPW; b++) begin : g_bytechk
        assign byte_bad[b] = (^word[b*8 +: 8]) != e.par[int'(fa.off)*BPW + b];
    end

    assign tag_bad = (^e.tag) != e.par[PAR_W-1];
    assign perr    = e.valid && (tag_bad || (|byte_bad));
    assign hit     = e.valid && (e.tag == fa.tag) && !perr;
endmodule

// File: rtl/dmc_ctrl.sv
`timescale 1ns/1ps
module dmc_ctrl import dmc_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  cpu_req,
    input  logic  cpu_we,
    input  addr_t cpu_addr,
    input  word_t cpu_wdata,
    input  logic  hit,
    input  logic  perr,
    input  logic  mem_ready,
    output addr_t lk_addr,
    output logic  mem_req,
    output logic  mem_we,
    output addr_t mem_addr,
    output word_t mem_wdata,
    output logic  cpu_ready,
    output logic  fill_en,
    output logic  wr_en,
    output logic  parity_err
);
    ctl_state_e state_q, state_d;
    addr_t addr_q;
    word_t wdata_q;
    logic  perr_q;
    logic  idle, rd_lookup;

    assign idle      = (state_q == ST_IDLE);
    assign rd_lookup = idle && cpu_req && !cpu_we;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (cpu_req && cpu_we)  state_d = ST_WRITE;
                else if (rd_lookup && !hit) state_d = ST_FILL;
            end
            default: if (mem_ready) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            perr_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (idle && cpu_req) begin
                addr_q  <= cpu_addr;
                wdata_q <= cpu_wdata;
            end
            if (rd_lookup && perr) perr_q <= 1'b1;
        end
    end

    assign lk_addr    = idle ? cpu_addr : addr_q;
    assign mem_req    = !idle;
    assign mem_we     = (state_q == ST_WRITE);
    assign mem_addr   = (state_q == ST_FILL) ? {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} : addr_q;
    assign mem_wdata  = wdata_q;
    assign fill_en    = (state_q == ST_FILL) && mem_ready;
    assign wr_en      = mem_we && mem_ready && hit;
    assign cpu_ready  = (rd_lookup && hit) || (mem_we && mem_ready);
    assign parity_err = perr_q;
endmodule

// File: rtl/dm_cache.sv
`timescale 1ns/1ps
module dm_cache import dmc_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [LINE_W-1:0] mem_rdata,
    input  logic              mem_ready,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              parity_err
);
    addr_t   lk_addr;
    addr_f_t lk_f, sn_f;
    entry_t  rd_entry;
    logic    hit, perr, fill_en, wr_en, inv_en, snp_v;
    tag_t    snp_tag;

    assign lk_f = split_addr(lk_addr);
    assign sn_f = split_addr(snoop_addr);

    // Snoop kills a matching line, and any line whose fill lands this cycle.
    assign inv_en = snoop_valid &&
                    ((snp_v && snp_tag == sn_f.tag) || (fill_en && lk_f.idx == sn_f.idx));

    dmc_ctrl u_ctrl (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .hit(hit), .perr(perr),
        .mem_ready(mem_ready), .lk_addr(lk_addr), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cpu_ready(cpu_ready), .fill_en(fill_en), .wr_en(wr_en),
        .parity_err(parity_err)
    );

    dmc_store u_store (
        .clk(clk), .rst(rst), .rd_idx(lk_f.idx), .rd_entry(rd_entry),
        .snp_idx(sn_f.idx), .snp_valid(snp_v), .snp_tag(snp_tag),
        .fill_en(fill_en), .fill_idx(lk_f.idx), .fill_tag(lk_f.tag),
        .fill_data(mem_rdata), .wr_en(wr_en), .wr_idx(lk_f.idx),
        .wr_off(lk_f.off), .wr_word(mem_wdata), .inv_en(inv_en),
        .inv_idx(sn_f.idx)
    );

    dmc_lookup u_lookup (
        .fa(lk_f), .e(rd_entry), .hit(hit), .perr(perr), .word(cpu_rdata)
    );
endmodule

// File: rtl/dm_cache_chk.sv
`timescale 1ns/1ps
module dm_cache_chk import dmc_pkg::*; (
    input logic              clk,
    input logic              rst,
    input logic              cpu_we,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ready,
    input logic              parity_err
);
    // R1: the cycle after reset is quiet
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mem_req && !parity_err));

    // R3: line fetches are aligned to the line
    assert_fill_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> (mem_addr[OFF_W-1:0] == '0));

    // R3: processor waits for the whole fill
    assert_fill_blocks_cpu_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> !cpu_ready);

    // R3: memory request held steady until accepted
    assert_req_held_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    // R5: a write completes only with the memory acknowledgement
    assert_write_through_R5: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && cpu_we) |-> (mem_req && mem_we && mem_ready));

    // R9: the error flag never drops outside reset
    assert_perr_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        parity_err |=> parity_err);
endmodule

bind dm_cache dm_cache_chk u_chk (.*);

// File: tb/dm_cache_bench.sv
`timescale 1ns/1ps
module dm_cache_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0, cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ready;
    logic        snoop_valid;
    logic [15:0] snoop_addr;
    logic        parity_err;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    dm_cache u_dm_cache (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .snoop_valid(snoop_valid),
        .snoop_addr(snoop_addr), .parity_err(parity_err)
    );

    // ---------------- memory and other-master model ----------------
    localparam int LAT = 2;
    logic [15:0] mem [256];
    logic [15:0] last_addr, last_wdata;
    logic        last_we;
    int          cnt;
    logic [15:0] ext_addr = '0, ext_data = '0;
    int ext_now_req = 0, ext_early_req = 0, ext_late_req = 0;
    int ext_now_done = 0, ext_early_done = 0, ext_late_done = 0;

    task automatic ext_write;   // other master writes memory, seen by snoop
        mem[ext_addr[7:0]] = ext_data;
        snoop_valid = 1'b1;
        snoop_addr  = ext_addr;
    endtask

    always @(negedge clk) begin
        snoop_valid = 1'b0;
        if (rst) begin
            mem_ready = 1'b0;
            mem_rdata = '0;
            snoop_addr = '0;
            cnt = 0;
            for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h1F3B) ^ 16'h6C21;
        end else begin
            if (ext_now_req != ext_now_done) begin
                ext_now_done = ext_now_req;
                ext_write();
            end
            if (mem_ready) begin
                mem_ready = 1'b0;
                cnt = 0;
            end else if (mem_req) begin
                if (cnt == LAT - 1) begin
                    mem_ready  = 1'b1;
                    last_addr  = mem_addr;
                    last_we    = mem_we;
                    last_wdata = mem_wdata;
                    if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
                    else mem_rdata = {mem[{mem_addr[7:1], 1'b1}], mem[{mem_addr[7:1], 1'b0}]};
                    if (ext_late_req != ext_late_done) begin
                        ext_late_done = ext_late_req;
                        ext_write();
                    end
                end else begin
                    if (ext_early_req != ext_early_done) begin
                        ext_early_done = ext_early_req;
                        ext_write();
                    end
                    cnt++;
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic cpu_access(input logic we, input logic [15:0] a, input logic [15:0] wd,
                              output logic [15:0] d, output int lat);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        lat = 0;
        #1;
        while (!cpu_ready) begin
            @(negedge clk); #1;
            lat++;
        end
        d = cpu_rdata;
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [15:0] a, input int exp_lat);
        logic [15:0] d;
        int lat;
        cpu_access(1'b0, a, 16'h0, d, lat);
        chk(tag, "read latency", 32'(lat), 32'(exp_lat));
        chk(tag, "read data", {16'h0, d}, {16'h0, mem[a[7:0]]});
    endtask

    task automatic wr_check(input string tag, input logic [15:0] a, input logic [15:0] wd);
        logic [15:0] d;
        int lat;
        cpu_access(1'b1, a, wd, d, lat);
        chk(tag, "write latency", 32'(lat), 32'd2);
        chk(tag, "write request", {15'h0, last_we, last_addr}, {15'h0, 1'b1, a});
        chk(tag, "write data", {16'h0, last_wdata}, {16'h0, wd});
    endtask

    // address, expected latency
    localparam logic [19:0] VECS [7] = '{
        {16'h0013, 4'd3},   // R1 empty after reset, R3 fill of odd word
        {16'h0012, 4'd0},   // R3 neighbour prefetched, R2 hit
        {16'h0013, 4'd0},   // R2 odd word select
        {16'h0032, 4'd3},   // R4 same index 9, tag 1
        {16'h0013, 4'd3},   // R4 evicted by conflict
        {16'h0005, 4'd3},   // R3 index 2
        {16'h0004, 4'd0}    // R2 even word
    };

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1", "ready after reset", {31'h0, cpu_ready}, 32'h0);
        chk("R1", "mem_req after reset", {31'h0, mem_req}, 32'h0);
        chk("R1", "parity_err after reset", {31'h0, parity_err}, 32'h0);

        for (int i = 0; i < 7; i++) begin
            rd_check("R2/R3/R4 table", VECS[i][19:4], int'(VECS[i][3:0]));
            if (VECS[i][3:0] == 4'd3)
                chk("R3", "fill request", {15'h0, last_we, last_addr},
                    {15'h0, 1'b0, VECS[i][19:5], 1'b0});
        end

        // R5 write hit updates the line, other word untouched
        wr_check("R5", 16'h0005, 16'hBEEF);
        rd_check("R5", 16'h0005, 0);
        rd_check("R5", 16'h0004, 0);
        // R5 write miss does not allocate
        wr_check("R5", 16'h0080, 16'h7E57);
        rd_check("R5", 16'h0080, 3);

        // R6 matching snoop during a hit: hit not stalled, line dropped
        @(posedge clk); #1;
        ext_addr = 16'h0013; ext_data = 16'h1234; ext_now_req++;
        rd_check("R6", 16'h0004, 0);
        rd_check("R6", 16'h0012, 3);
        rd_check("R6", 16'h0013, 0);
        // R6 snoop with other tag on the same index has no effect
        @(posedge clk); #1;
        ext_addr = 16'h0033; ext_data = 16'h4321; ext_now_req++;
        @(negedge clk); @(posedge clk);
        rd_check("R6", 16'h0013, 0);

        // R7 snoop in the fill completion cycle: line invalid, refill
        @(posedge clk); #1;
        ext_addr = 16'h0044; ext_data = 16'hA11E; ext_late_req++;
        rd_check("R7", 16'h0044, 6);
        rd_check("R7", 16'h0044, 0);
        // R7 snoop one cycle before completion: fill stands
        @(posedge clk); #1;
        ext_addr = 16'h0065; ext_data = 16'hE11E; ext_early_req++;
        rd_check("R7", 16'h0064, 3);
        rd_check("R7", 16'h0065, 0);

        // R8 parity fault injected into the stored check bits
        rd_check("R8", 16'h0060, 3);
        chk("R8", "no error before fault", {31'h0, parity_err}, 32'h0);
        force u_dm_cache.u_store.par_q = '1;
        #1;
        release u_dm_cache.u_store.par_q;
        rd_check("R8", 16'h0060, 3);
        chk("R8", "error flag raised", {31'h0, parity_err}, 32'h1);
        rd_check("R8", 16'h0060, 0);
        chk("R9", "error flag sticky", {31'h0, parity_err}, 32'h1);

        // R9/R1 reset clears flag and empties the cache
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R9", "flag cleared by reset", {31'h0, parity_err}, 32'h0);
        chk("R1", "idle after reset", {30'h0, mem_req, cpu_ready}, 32'h0);
        rd_check("R1", 16'h0060, 3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule